// File: doc/BRIEF.md
# Per-CPU Blocked-Context Wakeup Scanner

This block keeps the notification fields of a set of per-context interrupt descriptors in step with each context's run state. When the scheduler reports a run-state change for a context, the block issues a one-cycle descriptor update. The update carries the notification vector, the suppress flag and, for a context that starts running, the destination CPU. A context that blocks is placed on a list owned by the physical CPU it last ran on. When the context leaves the blocked state, it is taken off that list.

Posted notifications for blocked contexts use a dedicated wakeup vector. A blocked context's wakeup is therefore never taken by whichever context now occupies its CPU. When a wakeup-vector interrupt reaches a CPU, the block walks that CPU's blocked list one entry per cycle. For each entry whose outstanding-notification flag is set, it emits an unblock event and removes the entry. Entries without the flag stay on the list.

The lists are doubly linked entries in a fixed table with a head and a tail per CPU. Inserting or removing an entry takes one clock. The scan controller has three states:

- `SC_IDLE` waits for a wakeup. On a wakeup it moves to `SC_LOAD`.
- `SC_LOAD` fetches the list head. It moves to `SC_WALK`, or back to `SC_IDLE` when the list is empty.
- `SC_WALK` visits one entry per cycle. It returns to `SC_IDLE` after the last entry.

Top module: `blk_wake_scan`

## Requirements
- R1: A command with state code 2'b00 (running) produces, on the cycle after its acceptance edge, `desc_vld`=1 with `desc_nv`=POST_VEC, `desc_sn`=0, `desc_dst_we`=1 and `desc_dst` equal to `cmd_cpu`. It also records `cmd_cpu` as the context's last CPU.
- R2: A command with state code 2'b01 (blocked) produces a descriptor update with `desc_nv`=WAKE_VEC, `desc_sn`=0 and `desc_dst_we`=0.
- R3: A command with state code 2'b10 (runnable) or 2'b11 (offline) produces a descriptor update with `desc_sn`=1, `desc_nv`=POST_VEC and `desc_dst_we`=0.
- R4: A blocked command for a context not yet listed appends the context to the tail of the list of its last CPU. Any other state for a listed context removes it from that list. A blocked command for a context already listed leaves the lists unchanged.
- R5: A wakeup accepted for CPU c scans only CPU c's list. Every entry whose bit in `on_flags` is set produces an unblock event carrying its context ID and is removed, so a later scan does not report it again.
- R6: Unblock events come at most one per cycle, in list (insertion) order. The first one can appear two cycles after the wakeup acceptance edge. Entries whose flag is clear stay listed.
- R7: When all NUM_SLOTS entries are in use, a blocked command for an unlisted context pulses `ovf_err` for one cycle with its descriptor update. The context is not listed.
- R8: While a scan is in progress, `wake_ready` is 0. `cmd_ready` is 0 exactly when the commanded context's last CPU is the CPU being scanned. A stalled command changes nothing until it is accepted.
- R9: After reset all lists are empty, every context's last CPU is 0, all output pulses are 0, and both ready outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_vld | input | 1 | Run-state change command present |
| cmd_ready | output | 1 | Command accepted on this edge when high |
| cmd_state | input | 2 | New run state: 00 running, 01 blocked, 10 runnable, 11 offline |
| cmd_ctx | input | $clog2(NUM_CTX) | Context ID of the command |
| cmd_cpu | input | $clog2(NUM_CPU) | CPU the context will run on (used for running) |
| wake_vld | input | 1 | Wakeup-vector interrupt received |
| wake_ready | output | 1 | High when no scan is in progress |
| wake_cpu | input | $clog2(NUM_CPU) | CPU that received the wakeup |
| on_flags | input | NUM_CTX | Outstanding-notification flag per context |
| desc_vld | output | 1 | Descriptor update pulse |
| desc_ctx | output | $clog2(NUM_CTX) | Context whose descriptor is updated |
| desc_nv | output | VEC_W | New notification vector |
| desc_sn | output | 1 | New suppress flag |
| desc_dst_we | output | 1 | Destination field is written |
| desc_dst | output | DST_W | New destination CPU |
| unblk_vld | output | 1 | Unblock event pulse |
| unblk_ctx | output | $clog2(NUM_CTX) | Context to unblock |
| ovf_err | output | 1 | Blocked list table was full for an insert |

## Verification
A behavioural model built from per-CPU queues predicts every output on every cycle. The stimulus covers several cases:

- Lists with mixed flag patterns. These separate correct flag filtering and list order from simply unblocking the whole list.
- A repeated wakeup on the same CPU. This shows that emitted entries were really removed.
- A wakeup on an empty list and on a list whose entry left through a runnable command. These confirm removal on state exit.
- Blocking more contexts than there are slots. This exercises the overflow pulse.
- Commands issued during a scan, one for the scanned CPU and one for another CPU. These separate the per-CPU stall from a global stall.

// File: rtl/bws_pkg.sv
package bws_pkg;
    typedef enum logic [1:0] {
        RS_RUN   = 2'b00,
        RS_BLOCK = 2'b01,
        RS_READY = 2'b10,
        RS_OFF   = 2'b11
    } run_state_e;

    typedef enum logic [1:0] {
        SC_IDLE = 2'b00,
        SC_LOAD = 2'b01,
        SC_WALK = 2'b10
    } scan_state_e;
endpackage

// File: rtl/bws_list_table.sv
module bws_list_table #(
    parameter int NS  = 6,
    parameter int NC  = 8,
    parameter int NP  = 4,
    localparam int CW  = $clog2(NC),
    localparam int PCW = $clog2(NP),
    localparam int PW  = $clog2(NS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ins_en,
    input  logic [CW-1:0]  ins_ctx,
    input  logic [PCW-1:0] ins_cpu,
    input  logic           rm_en,
    input  logic [CW-1:0]  rm_ctx,
    input  logic [PCW-1:0] rm_cpu,
    input  logic           srm_en,
    input  logic [PW-1:0]  srm_slot,
    input  logic [PCW-1:0] srm_cpu,
    input  logic [CW-1:0]  q_ctx,
    output logic           q_in,
    output logic           full,
    input  logic [PCW-1:0] rd_cpu,
    output logic [PW-1:0]  rd_head,
    input  logic [PW-1:0]  rd_slot,
    output logic [PW-1:0]  rd_nxt,
    output logic [CW-1:0]  rd_ctx
);
    localparam logic [PW-1:0] NIL = PW'(NS);

    // entry NS is a never-used placeholder addressed by the null pointer
    logic           s_vld [NS+1];
    logic [PW-1:0]  s_nxt [NS+1];
    logic [PW-1:0]  s_prv [NS+1];
    logic [CW-1:0]  s_ctx [NS+1];
    logic [PW-1:0]  head  [NP];
    logic [PW-1:0]  tail  [NP];
    logic           c_in  [NC];
    logic [PW-1:0]  c_slot[NC];

    logic [PW-1:0] free_slot;
    logic [PW-1:0] rm_slot, rm_p, rm_n, sr_p, sr_n, ins_t;

    always_comb begin
        free_slot = NIL;
        full      = 1'b1;
        for (int i = NS - 1; i >= 0; i--) begin
            if (!s_vld[i]) begin
                free_slot = PW'(i);
                full      = 1'b0;
            end
        end
    end

    assign rm_slot = c_slot[rm_ctx];
    assign rm_p    = s_prv[rm_slot];
    assign rm_n    = s_nxt[rm_slot];
    assign sr_p    = s_prv[srm_slot];
    assign sr_n    = s_nxt[srm_slot];
    assign ins_t   = tail[ins_cpu];

    assign q_in    = c_in[q_ctx];
    assign rd_head = head[rd_cpu];
    assign rd_nxt  = s_nxt[rd_slot];
    assign rd_ctx  = s_ctx[rd_slot];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= NS; i++) begin
                s_vld[i] <= 1'b0;
                s_nxt[i] <= NIL;
                s_prv[i] <= NIL;
                s_ctx[i] <= '0;
            end
            for (int i = 0; i < NP; i++) begin
                head[i] <= NIL;
                tail[i] <= NIL;
            end
            for (int i = 0; i < NC; i++) begin
                c_in[i]   <= 1'b0;
                c_slot[i] <= NIL;
            end
        end else begin
            // removal requested by the scanner (list of srm_cpu)
            if (srm_en) begin
                s_vld[srm_slot]       <= 1'b0;
                c_in[s_ctx[srm_slot]] <= 1'b0;
                if (sr_p == NIL) head[srm_cpu] <= sr_n;
                else             s_nxt[sr_p]   <= sr_n;
                if (sr_n == NIL) tail[srm_cpu] <= sr_p;
                else             s_prv[sr_n]   <= sr_p;
            end
            // removal requested by a state change (never the scanned list)
            if (rm_en) begin
                s_vld[rm_slot] <= 1'b0;
                c_in[rm_ctx]   <= 1'b0;
                if (rm_p == NIL) head[rm_cpu] <= rm_n;
                else             s_nxt[rm_p]  <= rm_n;
                if (rm_n == NIL) tail[rm_cpu] <= rm_p;
                else             s_prv[rm_n]  <= rm_p;
            end
            // tail append into a free slot
            if (ins_en) begin
                s_vld[free_slot] <= 1'b1;
                s_ctx[free_slot] <= ins_ctx;
                s_nxt[free_slot] <= NIL;
                s_prv[free_slot] <= ins_t;
                if (ins_t == NIL) head[ins_cpu] <= free_slot;
                else              s_nxt[ins_t]  <= free_slot;
                tail[ins_cpu]   <= free_slot;
                c_in[ins_ctx]   <= 1'b1;
                c_slot[ins_ctx] <= free_slot;
            end
        end
    end
endmodule

// File: rtl/bws_scan_fsm.sv
module bws_scan_fsm
    import bws_pkg::*;
#(
    parameter int NS = 6,
    parameter int NC = 8,
    parameter int NP = 4,
    localparam int CW  = $clog2(NC),
    localparam int PCW = $clog2(NP),
    localparam int PW  = $clog2(NS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wake_vld,
    input  logic [PCW-1:0] wake_cpu,
    output logic           wake_ready,
    input  logic [NC-1:0]  on_flags,
    input  logic [PW-1:0]  rd_head,
    output logic [PW-1:0]  rd_slot,
    input  logic [PW-1:0]  rd_nxt,
    input  logic [CW-1:0]  rd_ctx,
    output logic           busy,
    output logic [PCW-1:0] scan_cpu,
    output logic           srm_en,
    output logic [PW-1:0]  srm_slot,
    output logic           unblk_vld,
    output logic [CW-1:0]  unblk_ctx
);
    localparam logic [PW-1:0] NIL = PW'(NS);

    scan_state_e    state_q, state_d;
    logic [PW-1:0]  cur_q, cur_d;
    logic [PCW-1:0] cpu_q, cpu_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            cur_q   <= NIL;
            cpu_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            cpu_q   <= cpu_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        cpu_d   = cpu_q;
        srm_en  = 1'b0;
        unique case (state_q)
            SC_IDLE: begin
                if (wake_vld) begin
                    state_d = SC_LOAD;
                    cpu_d   = wake_cpu;
                end
            end
            SC_LOAD: begin
                cur_d   = rd_head;
                state_d = (rd_head == NIL) ? SC_IDLE : SC_WALK;
            end
            SC_WALK: begin
                srm_en  = on_flags[rd_ctx];
                cur_d   = rd_nxt;
                if (rd_nxt == NIL) state_d = SC_IDLE;
            end
            default: state_d = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unblk_vld <= 1'b0;
            unblk_ctx <= '0;
        end else begin
            unblk_vld <= srm_en;
            unblk_ctx <= rd_ctx;
        end
    end

    assign wake_ready = (state_q == SC_IDLE);
    assign busy       = !wake_ready;
    assign scan_cpu   = cpu_q;
    assign rd_slot    = cur_q;
    assign srm_slot   = cur_q;
endmodule

// File: rtl/bws_desc_enc.sv
module bws_desc_enc
    import bws_pkg::*;
#(
    parameter int CW    = 3,
    parameter int PCW   = 2,
    parameter int VEC_W = 8,
    parameter int DST_W = 8,
    parameter logic [VEC_W-1:0] POST_VEC = 'hF2,
    parameter logic [VEC_W-1:0] WAKE_VEC = 'hF1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  run_state_e       state,
    input  logic [CW-1:0]    ctx,
    input  logic [PCW-1:0]   cpu,
    input  logic             ovf_in,
    output logic             desc_vld,
    output logic [CW-1:0]    desc_ctx,
    output logic [VEC_W-1:0] desc_nv,
    output logic             desc_sn,
    output logic             desc_dst_we,
    output logic [DST_W-1:0] desc_dst,
    output logic             ovf_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_vld    <= 1'b0;
            desc_ctx    <= '0;
            desc_nv     <= '0;
            desc_sn     <= 1'b0;
            desc_dst_we <= 1'b0;
            desc_dst    <= '0;
            ovf_err     <= 1'b0;
        end else begin
            desc_vld    <= acc;
            desc_ctx    <= ctx;
            desc_dst    <= DST_W'(cpu);
            ovf_err     <= acc && ovf_in;
            unique case (state)
                RS_RUN: begin
                    desc_nv     <= POST_VEC;
                    desc_sn     <= 1'b0;
                    desc_dst_we <= acc;
                end
                RS_BLOCK: begin
                    desc_nv     <= WAKE_VEC;
                    desc_sn     <= 1'b0;
                    desc_dst_we <= 1'b0;
                end
                default: begin
                    desc_nv     <= POST_VEC;
                    desc_sn     <= 1'b1;
                    desc_dst_we <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/blk_wake_scan.sv
module blk_wake_scan
    import bws_pkg::*;
#(
    parameter int NUM_CTX   = 8,
    parameter int NUM_CPU   = 4,
    parameter int NUM_SLOTS = 6,
    parameter int VEC_W     = 8,
    parameter int DST_W     = 8,
    parameter logic [VEC_W-1:0] POST_VEC = 'hF2,
    parameter logic [VEC_W-1:0] WAKE_VEC = 'hF1,
    localparam int CW  = $clog2(NUM_CTX),
    localparam int PCW = $clog2(NUM_CPU),
    localparam int PW  = $clog2(NUM_SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_vld,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_state,
    input  logic [CW-1:0]      cmd_ctx,
    input  logic [PCW-1:0]     cmd_cpu,
    input  logic               wake_vld,
    output logic               wake_ready,
    input  logic [PCW-1:0]     wake_cpu,
    input  logic [NUM_CTX-1:0] on_flags,
    output logic               desc_vld,
    output logic [CW-1:0]      desc_ctx,
    output logic [VEC_W-1:0]   desc_nv,
    output logic               desc_sn,
    output logic               desc_dst_we,
    output logic [DST_W-1:0]   desc_dst,
    output logic               unblk_vld,
    output logic [CW-1:0]      unblk_ctx,
    output logic               ovf_err
);
    run_state_e     st;
    logic           acc, busy, listed, full;
    logic           ins_en, rm_en, srm_en, ovf_now;
    logic [PCW-1:0] scan_cpu, home_cpu;
    logic [PW-1:0]  rd_head, rd_slot, rd_nxt, srm_slot;
    logic [CW-1:0]  rd_ctx;
    logic [PCW-1:0] last_cpu [NUM_CTX];

    assign st        = run_state_e'(cmd_state);
    assign home_cpu  = last_cpu[cmd_ctx];
    assign cmd_ready = !(busy && (home_cpu == scan_cpu));
    assign acc       = cmd_vld && cmd_ready;
    assign ins_en    = acc && (st == RS_BLOCK) && !listed && !full;
    assign ovf_now   = (st == RS_BLOCK) && !listed && full;
    assign rm_en     = acc && (st != RS_BLOCK) && listed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CTX; i++) last_cpu[i] <= '0;
        end else if (acc && st == RS_RUN) begin
            last_cpu[cmd_ctx] <= cmd_cpu;
        end
    end

    bws_list_table #(.NS(NUM_SLOTS), .NC(NUM_CTX), .NP(NUM_CPU)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (ins_en),
        .ins_ctx  (cmd_ctx),
        .ins_cpu  (home_cpu),
        .rm_en    (rm_en),
        .rm_ctx   (cmd_ctx),
        .rm_cpu   (home_cpu),
        .srm_en   (srm_en),
        .srm_slot (srm_slot),
        .srm_cpu  (scan_cpu),
        .q_ctx    (cmd_ctx),
        .q_in     (listed),
        .full     (full),
        .rd_cpu   (scan_cpu),
        .rd_head  (rd_head),
        .rd_slot  (rd_slot),
        .rd_nxt   (rd_nxt),
        .rd_ctx   (rd_ctx)
    );

    bws_scan_fsm #(.NS(NUM_SLOTS), .NC(NUM_CTX), .NP(NUM_CPU)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_vld   (wake_vld),
        .wake_cpu   (wake_cpu),
        .wake_ready (wake_ready),
        .on_flags   (on_flags),
        .rd_head    (rd_head),
        .rd_slot    (rd_slot),
        .rd_nxt     (rd_nxt),
        .rd_ctx     (rd_ctx),
        .busy       (busy),
        .scan_cpu   (scan_cpu),
        .srm_en     (srm_en),
        .srm_slot   (srm_slot),
        .unblk_vld  (unblk_vld),
        .unblk_ctx  (unblk_ctx)
    );

    bws_desc_enc #(
        .CW(CW), .PCW(PCW), .VEC_W(VEC_W), .DST_W(DST_W),
        .POST_VEC(POST_VEC), .WAKE_VEC(WAKE_VEC)
    ) u_desc (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc         (acc),
        .state       (st),
        .ctx         (cmd_ctx),
        .cpu         (cmd_cpu),
        .ovf_in      (ovf_now),
        .desc_vld    (desc_vld),
        .desc_ctx    (desc_ctx),
        .desc_nv     (desc_nv),
        .desc_sn     (desc_sn),
        .desc_dst_we (desc_dst_we),
        .desc_dst    (desc_dst),
        .ovf_err     (ovf_err)
    );
endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
    parameter int CW    = 3,
    parameter int VEC_W = 8,
    parameter logic [VEC_W-1:0] POST_VEC = 'hF2,
    parameter logic [VEC_W-1:0] WAKE_VEC = 'hF1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_vld,
    input logic             cmd_ready,
    input logic [1:0]       cmd_state,
    input logic             wake_ready,
    input logic             desc_vld,
    input logic [VEC_W-1:0] desc_nv,
    input logic             desc_sn,
    input logic             desc_dst_we,
    input logic             unblk_vld,
    input logic [CW-1:0]    unblk_ctx,
    input logic             ovf_err
);
    AST_RUN_DST: assert property (@(posedge clk) disable iff (!rst_n)
        desc_vld && desc_dst_we |-> desc_nv == POST_VEC && !desc_sn); // R1
    AST_BLOCK_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        desc_vld && desc_nv == WAKE_VEC && WAKE_VEC != POST_VEC |-> !desc_sn && !desc_dst_we); // R2
    AST_SUPPRESS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        desc_vld && desc_sn |-> desc_nv == POST_VEC && !desc_dst_we); // R3
    AST_UNBLK_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        unblk_vld |-> $past(!wake_ready)); // R5
    AST_UNBLK_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        unblk_vld |=> !unblk_vld || unblk_ctx != $past(unblk_ctx)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> $past(cmd_vld && cmd_ready && cmd_state == 2'b01)); // R7
    AST_DESC_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        desc_vld |-> $past(cmd_vld && cmd_ready)); // R8
endmodule

bind blk_wake_scan bws_checker #(
    .CW(CW), .VEC_W(VEC_W), .POST_VEC(POST_VEC), .WAKE_VEC(WAKE_VEC)
) u_bws_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_vld     (cmd_vld),
    .cmd_ready   (cmd_ready),
    .cmd_state   (cmd_state),
    .wake_ready  (wake_ready),
    .desc_vld    (desc_vld),
    .desc_nv     (desc_nv),
    .desc_sn     (desc_sn),
    .desc_dst_we (desc_dst_we),
    .unblk_vld   (unblk_vld),
    .unblk_ctx   (unblk_ctx),
    .ovf_err     (ovf_err)
);

// File: tb/blk_wake_scan_test.sv
module blk_wake_scan_test;
    localparam int NCX = 8;
    localparam int NCP = 4;
    localparam int NSL = 6;
    localparam logic [7:0] PV = 8'hF2;
    localparam logic [7:0] WV = 8'hF1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_vld = 1'b0;
    logic [1:0] cmd_state = 2'b00;
    logic [2:0] cmd_ctx = '0;
    logic [1:0] cmd_cpu = '0;
    logic       wake_vld = 1'b0;
    logic [1:0] wake_cpu = '0;
    logic [7:0] on_flags = '0;
    logic       cmd_ready, wake_ready, desc_vld, desc_sn, desc_dst_we;
    logic       unblk_vld, ovf_err;
    logic [2:0] desc_ctx, unblk_ctx;
    logic [7:0] desc_nv, desc_dst;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    blk_wake_scan #(
        .NUM_CTX(NCX), .NUM_CPU(NCP), .NUM_SLOTS(NSL),
        .VEC_W(8), .DST_W(8), .POST_VEC(PV), .WAKE_VEC(WV)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_vld(cmd_vld), .cmd_ready(cmd_ready), .cmd_state(cmd_state),
        .cmd_ctx(cmd_ctx), .cmd_cpu(cmd_cpu),
        .wake_vld(wake_vld), .wake_ready(wake_ready), .wake_cpu(wake_cpu),
        .on_flags(on_flags),
        .desc_vld(desc_vld), .desc_ctx(desc_ctx), .desc_nv(desc_nv),
        .desc_sn(desc_sn), .desc_dst_we(desc_dst_we), .desc_dst(desc_dst),
        .unblk_vld(unblk_vld), .unblk_ctx(unblk_ctx), .ovf_err(ovf_err)
    );

    // ---------------- behavioural reference model ----------------
    int   lq [NCP][$];
    bit   inl [NCX];
    int   lcpu [NCX];
    int   mst;       // 0 idle, 1 fetching head, 2 walking
    int   scpu, sidx;
    bit   e_dv, e_sn, e_dwe, e_ub, e_ovf;
    int   e_dctx, e_nv, e_dst, e_uctx, e_st;
    int   ub_seen[$];
    int   ovf_seen;

    function automatic bit m_cmd_ready();
        return !(mst != 0 && lcpu[cmd_ctx] == scpu);
    endfunction

    function automatic void m_drop(int c, int x);
        for (int i = 0; i < lq[c].size(); i++)
            if (lq[c][i] == x) begin lq[c].delete(i); break; end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCP; i++) lq[i].delete();
            for (int i = 0; i < NCX; i++) begin inl[i] = 0; lcpu[i] = 0; end
            mst = 0; scpu = 0; sidx = 0;
            e_dv = 0; e_sn = 0; e_dwe = 0; e_ub = 0; e_ovf = 0;
            e_dctx = 0; e_nv = 0; e_dst = 0; e_uctx = 0; e_st = 0;
        end else begin
            bit cacc, wacc;
            int tot;
            cacc = cmd_vld && m_cmd_ready();
            wacc = wake_vld && (mst == 0);
            tot = 0;
            for (int i = 0; i < NCP; i++) tot += lq[i].size();
            e_dv = 0; e_ub = 0; e_ovf = 0;
            if (mst == 1) begin
                if (lq[scpu].size() == 0) mst = 0;
                else begin mst = 2; sidx = 0; end
            end else if (mst == 2) begin
                int c;
                c = lq[scpu][sidx];
                if (on_flags[c]) begin
                    e_ub = 1; e_uctx = c;
                    lq[scpu].delete(sidx); inl[c] = 0;
                end else sidx++;
                if (sidx >= lq[scpu].size()) mst = 0;
            end else if (wacc) begin
                mst = 1; scpu = int'(wake_cpu);
            end
            if (cacc) begin
                int x;
                x = int'(cmd_ctx);
                e_dv = 1; e_dctx = x; e_st = int'(cmd_state);
                e_dst = int'(cmd_cpu);
                case (cmd_state)
                    2'b00: begin e_nv = PV; e_sn = 0; e_dwe = 1; end
                    2'b01: begin e_nv = WV; e_sn = 0; e_dwe = 0; end
                    default: begin e_nv = PV; e_sn = 1; e_dwe = 0; end
                endcase
                if (cmd_state == 2'b01) begin
                    if (!inl[x]) begin
                        if (tot >= NSL) e_ovf = 1;
                        else begin lq[lcpu[x]].push_back(x); inl[x] = 1; end
                    end
                end else if (inl[x]) begin
                    m_drop(lcpu[x], x); inl[x] = 0;
                end
                if (cmd_state == 2'b00) lcpu[x] = int'(cmd_cpu);
            end
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare every cycle, midway between the falling and rising edges
    always @(negedge clk) begin
        string dreq;
        #5;
        if (!rst_n) dreq = "R9";
        else if (!e_dv) dreq = "R8";
        else if (e_st == 0) dreq = "R1";
        else if (e_st == 1) dreq = "R2";
        else dreq = "R3";
        chk(cmd_ready == m_cmd_ready(), rst_n ? "R8" : "R9", "cmd_ready", cmd_ready, m_cmd_ready());
        chk(wake_ready == (mst == 0), rst_n ? "R8" : "R9", "wake_ready", wake_ready, mst == 0);
        chk(desc_vld == e_dv, dreq, "desc_vld", desc_vld, e_dv);
        if (e_dv) begin
            chk(desc_ctx == e_dctx, dreq, "desc_ctx", desc_ctx, e_dctx);
            chk(desc_nv == e_nv, dreq, "desc_nv", desc_nv, e_nv);
            chk(desc_sn == e_sn, dreq, "desc_sn", desc_sn, e_sn);
            chk(desc_dst_we == e_dwe, dreq, "desc_dst_we", desc_dst_we, e_dwe);
            if (e_dwe) chk(desc_dst == e_dst, "R1", "desc_dst", desc_dst, e_dst);
        end
        chk(unblk_vld == e_ub, "R4 R5 R6", "unblk_vld", unblk_vld, e_ub);
        if (e_ub) chk(unblk_ctx == e_uctx, "R4 R5 R6", "unblk_ctx", unblk_ctx, e_uctx);
        chk(ovf_err == e_ovf, "R7", "ovf_err", ovf_err, e_ovf);
        if (rst_n && unblk_vld) ub_seen.push_back(int'(unblk_ctx));
        if (rst_n && ovf_err) ovf_seen++;
    end

    // ---------------- stimulus ----------------
    int stall_cyc;

    task automatic do_cmd(logic [1:0] s, int ctx, int cpu);
        bit took;
        @(negedge clk);
        cmd_vld = 1; cmd_state = s; cmd_ctx = 3'(ctx); cmd_cpu = 2'(cpu);
        took = 0;
        while (!took) begin
            #5 took = cmd_ready;
            if (!took) stall_cyc++;
            @(negedge clk);
        end
        cmd_vld = 0;
    endtask

    task automatic do_wake(int cpu);
        bit took;
        @(negedge clk);
        wake_vld = 1; wake_cpu = 2'(cpu);
        took = 0;
        while (!took) begin
            #5 took = wake_ready;
            @(negedge clk);
        end
        wake_vld = 0;
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic expect_ub(string req, int a[$]);
        chk(ub_seen.size() == a.size(), req, "unblock count", ub_seen.size(), a.size());
        for (int i = 0; i < a.size() && i < ub_seen.size(); i++)
            chk(ub_seen[i] == a[i], req, "unblock order", ub_seen[i], a[i]);
        ub_seen.delete();
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        ovf_seen = 0; stall_cyc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: contexts start running on assorted CPUs
        do_cmd(2'b00, 0, 1); do_cmd(2'b00, 1, 1); do_cmd(2'b00, 2, 1);
        do_cmd(2'b00, 3, 2); do_cmd(2'b00, 4, 2); do_cmd(2'b00, 5, 3);
        do_cmd(2'b00, 6, 0); do_cmd(2'b00, 7, 3);
        // R2 R4: block three on CPU1, one on CPU2
        do_cmd(2'b01, 0, 0); do_cmd(2'b01, 1, 0); do_cmd(2'b01, 2, 0);
        do_cmd(2'b01, 3, 0);
        do_cmd(2'b01, 3, 0);                // already listed: no second entry
        on_flags = 8'b0000_0101;
        // R5: CPU2 entry has no flag set
        do_wake(2); settle(); expect_ub("R5", '{});
        // R5 R6: flagged entries of CPU1 in insertion order
        do_wake(1); settle(); expect_ub("R6", '{0, 2});
        // R5: emitted entries were removed; remaining one now flagged
        on_flags = 8'hFF;
        do_wake(1); settle(); expect_ub("R5", '{1});
        do_wake(0); settle(); expect_ub("R5", '{});
        // R4 R3: runnable takes ctx3 off CPU2 list
        do_cmd(2'b10, 3, 0);
        do_wake(2); settle(); expect_ub("R4", '{});
        // R7: eight blocks into six slots
        on_flags = 8'h00;
        for (int i = 0; i < 8; i++) do_cmd(2'b01, i, 0);
        repeat (2) @(negedge clk);
        chk(ovf_seen == 2, "R7", "overflow pulses", ovf_seen, 2);
        // R8: stall for the scanned CPU, no stall for another CPU
        on_flags = 8'h02;
        stall_cyc = 0;
        fork
            do_wake(1);
            begin @(negedge clk); do_cmd(2'b11, 0, 0); end
        join
        chk(stall_cyc > 0, "R8", "stalled cycles seen", stall_cyc, 1);
        settle(); expect_ub("R6", '{1});
        stall_cyc = 0;
        fork
            do_wake(1);
            begin @(negedge clk); do_cmd(2'b00, 4, 3); end
        join
        chk(stall_cyc == 0, "R8", "stall on other CPU", stall_cyc, 0);
        settle(); ub_seen.delete();
        on_flags = 8'hFF;
        do_wake(1); settle(); expect_ub("R6", '{2});
        do_wake(3); settle(); expect_ub("R5", '{5});
        do_wake(2); settle(); expect_ub("R5", '{3});
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule